// File: doc/BRIEF.md
# Interrupt flag pattern detector

This block watches a small set of interrupt flag inputs and, for each of several output channels, decides whether the flags that channel has been told to watch are all set at once. Software picks, per channel, which flags take part. A channel reports a match only when every selected flag is 1. When none are selected, it never reports a match. The match result for each channel is registered and driven out as a level.

Each channel can also raise a single-cycle trigger whenever its match result changes. The trigger fires when the match appears and again when it goes away. The same match result gates a per-channel request input, under one of four gating modes. Each channel drives a gated-request output and an interrupt-style output. The interrupt-style output is the gated request ORed with the change trigger.

Configuration is held in 32-bit control words. Each word carries two channels, one per 16-bit half. Software accesses the words through a plain write strobe, word address and combinational read data. The block has no streaming data path, so all pins are plain level signals with no handshake.

Top module: `flag_pattern_gate`

## Requirements
- R1: A channel's pattern is detected when every flag selected by its flag-select bits is 1. Flags that are not selected have no effect on that channel.
- R2: A channel whose flag-select bits are all 0 never reports a match, whatever the flag inputs are.
- R3: `match_out` is registered. A flag change driven before a rising clock edge shows on `match_out` after that edge and not before it.
- R4: With the event-enable bit set, `irq_out` for that channel is 1 for exactly one cycle when its match result goes from 0 to 1.
- R5: With the event-enable bit set, `irq_out` for that channel is 1 for exactly one cycle when its match result goes from 1 to 0.
- R6: With the event-enable bit clear, a change of the match result produces no pulse on `irq_out`.
- R7: The gating-mode field selects how `req_in` reaches `gate_out`, which is registered one cycle behind its inputs:
  - 00 passes the request unchanged.
  - 01 passes it only while the pattern is detected.
  - 10 passes it only while the pattern is not detected.
  - 11 always blocks it.
- R8: `irq_out` of a channel equals its gated request ORed with its change trigger, with the same one-cycle latency as `gate_out`.
- R9: Word 0 holds channel 0 in bits 15:0 and channel 1 in bits 31:16. Word 1 holds channels 2 and 3 the same way. Within a 16-bit half:
  - bits 3:0 are the flag-select bits, with bit n selecting flag n;
  - bit 13 is the event enable;
  - bits 15:14 are the gating mode.
- R10: Bits 12:4 of each half read as 0, and writes to them are ignored.
- R11: After reset, all control bits read 0 and `match_out`, `gate_out` and `irq_out` are 0. Leaving reset produces no trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| flag_in | input | 4 | Interrupt flag inputs |
| req_in | input | 4 | Per-channel request inputs to be gated |
| cfg_we | input | 1 | Control word write strobe |
| cfg_addr | input | 1 | Control word index |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read data, combinational from `cfg_addr` |
| match_out | output | 4 | Registered per-channel match result |
| gate_out | output | 4 | Registered per-channel gated request |
| irq_out | output | 4 | Registered gated request ORed with change trigger |

## Verification
The flag patterns used are:
- exactly the selected subset, which separates correct selection from any-flag logic;
- the selected subset plus an unselected flag, which shows that unselected flags are ignored;
- a partial subset, which separates AND from OR behaviour;
- all ones on a channel that selects nothing, which exposes a match on an empty selection.

Rising and falling match transitions are applied to two channels that differ only in event enable, with requests blocked, so any pulse on `irq_out` can only be the trigger. The four gating modes run side by side under both match states and with the request low, which tells each mode's encoding apart. An all-ones write and a mixed-bit write check the field layout and the reserved bits.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
  localparam int DATA_W   = 32;
  localparam int HALF_W   = 16;
  localparam int EVT_BIT  = 13;
  localparam int MODE_LSB = 14;

  typedef enum logic [1:0] {
    GM_PASS     = 2'b00,
    GM_ON_MATCH = 2'b01,
    GM_ON_MISS  = 2'b10,
    GM_BLOCK    = 2'b11
  } gate_mode_e;
endpackage

// File: rtl/fpg_cfg_regs.sv
module fpg_cfg_regs
  import fpg_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int NUM_FLAGS = 4,
  parameter int ADDR_W    = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata,
  output logic [NUM_CH-1:0][NUM_FLAGS-1:0] sel_o,
  output logic [NUM_CH-1:0]        evt_o,
  output gate_mode_e [NUM_CH-1:0]  mode_o
);
  localparam int CH_PER_WORD = DATA_W / HALF_W;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] WORD = ADDR_W'(c / CH_PER_WORD);
    localparam int BASE = (c % CH_PER_WORD) * HALF_W;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_o[c]  <= '0;
        evt_o[c]  <= 1'b0;
        mode_o[c] <= GM_PASS;
      end else if (we && addr == WORD) begin
        sel_o[c]  <= wdata[BASE +: NUM_FLAGS];
        evt_o[c]  <= wdata[BASE + EVT_BIT];
        mode_o[c] <= gate_mode_e'(wdata[BASE + MODE_LSB +: 2]);
      end
    end
  end

  // Read mux: reserved bits between the select field and the event bit stay zero.
  always_comb begin
    rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == ADDR_W'(c / CH_PER_WORD)) begin
        rdata[(c % CH_PER_WORD) * HALF_W +: NUM_FLAGS]    = sel_o[c];
        rdata[(c % CH_PER_WORD) * HALF_W + EVT_BIT]       = evt_o[c];
        rdata[(c % CH_PER_WORD) * HALF_W + MODE_LSB +: 2] = mode_o[c];
      end
    end
  end
endmodule

// File: rtl/fpg_chan.sv
module fpg_chan
  import fpg_pkg::*;
#(
  parameter int NUM_FLAGS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] flags,
  input  logic [NUM_FLAGS-1:0] sel,
  input  logic                 evt_en,
  input  gate_mode_e           mode,
  input  logic                 req,
  output logic                 match_q,
  output logic                 gate_q,
  output logic                 irq_q
);
  logic hit, trig, passed;

  // Match needs at least one selected flag and all selected flags high.
  assign hit  = (|sel) && ((flags & sel) == sel);
  assign trig = evt_en && (hit ^ match_q);

  always_comb begin
    unique case (mode)
      GM_PASS:     passed = req;
      GM_ON_MATCH: passed = req & hit;
      GM_ON_MISS:  passed = req & ~hit;
      default:     passed = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      gate_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      match_q <= hit;
      gate_q  <= passed;
      irq_q   <= passed | trig;
    end
  end
endmodule

// File: rtl/flag_pattern_gate.sv
module flag_pattern_gate
  import fpg_pkg::*;
#(
  parameter int NUM_FLAGS = 4,
  parameter int NUM_CH    = 4,
  localparam int NUM_WORDS = (NUM_CH + 1) / 2,
  localparam int ADDR_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] flag_in,
  input  logic [NUM_CH-1:0]    req_in,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  output logic [NUM_CH-1:0]    match_out,
  output logic [NUM_CH-1:0]    gate_out,
  output logic [NUM_CH-1:0]    irq_out
);
  logic [NUM_CH-1:0][NUM_FLAGS-1:0] sel;
  logic [NUM_CH-1:0]                evt;
  gate_mode_e [NUM_CH-1:0]          mode;

  fpg_cfg_regs #(.NUM_CH(NUM_CH), .NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata),
    .sel_o(sel), .evt_o(evt), .mode_o(mode)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    fpg_chan #(.NUM_FLAGS(NUM_FLAGS)) u_chan (
      .clk(clk), .rst_n(rst_n), .flags(flag_in), .sel(sel[c]),
      .evt_en(evt[c]), .mode(mode[c]), .req(req_in[c]),
      .match_q(match_out[c]), .gate_q(gate_out[c]), .irq_q(irq_out[c])
    );
  end
endmodule

// File: rtl/fpg_chk.sv
module fpg_chk #(
  parameter int NUM_FLAGS = 4,
  parameter int NUM_CH    = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_FLAGS-1:0] flag_in,
  input logic [NUM_CH-1:0]    req_in,
  input logic [31:0]          cfg_rdata,
  input logic [NUM_CH-1:0]    match_out,
  input logic [NUM_CH-1:0]    gate_out,
  input logic [NUM_CH-1:0]    irq_out
);
  assert_match_needs_flags_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (match_out != '0) |-> ($past(flag_in) != '0));

  assert_gate_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_out & ~$past(req_in)) == '0);

  assert_gate_within_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_out & ~irq_out) == '0);

  assert_lone_irq_on_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & ~gate_out & ~(match_out ^ $past(match_out))) == '0);

  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[12:NUM_FLAGS] == '0) && (cfg_rdata[28:16+NUM_FLAGS] == '0));
endmodule

bind flag_pattern_gate fpg_chk #(.NUM_FLAGS(NUM_FLAGS), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .flag_in(flag_in), .req_in(req_in),
  .cfg_rdata(cfg_rdata), .match_out(match_out), .gate_out(gate_out), .irq_out(irq_out)
);

// File: tb/flag_pattern_gate_test.sv
module flag_pattern_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  flag_in = '0;
  logic [3:0]  req_in = '0;
  logic        cfg_we = 1'b0;
  logic [0:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [3:0]  match_out, gate_out, irq_out;
  int checks = 0;
  int fails = 0;

  flag_pattern_gate uut (
    .clk(clk), .rst_n(rst_n), .flag_in(flag_in), .req_in(req_in),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .match_out(match_out), .gate_out(gate_out), .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a[0:0]; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    cfg_addr = a[0:0];
    #1;
    d = cfg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    repeat (3) step();
    rst_n = 1'b1;
    rd(0, d); check("R11 word0 reset", d, 32'h0);
    rd(1, d); check("R11 word1 reset", d, 32'h0);
    check("R11 match reset", match_out, 4'h0);
    check("R11 gate reset", gate_out, 4'h0);
    check("R11 irq reset", irq_out, 4'h0);
    repeat (2) step();
    check("R11 no trigger after reset", irq_out, 4'h0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    wr(0, 32'hFFFF_FFFF);
    rd(0, d); check("R9 R10 all-ones word0", d, 32'hE00F_E00F);
    wr(1, 32'h5A3C_9681);
    rd(1, d); check("R9 R10 mixed word1", d, 32'h400C_8001);
    rd(0, d); check("R9 word0 untouched by word1 write", d, 32'hE00F_E00F);
    wr(0, 32'h0); wr(1, 32'h0);
    rd(0, d); check("R9 word0 cleared", d, 32'h0);
  endtask

  task automatic t_select();
    wr(0, 32'h0000_0005);  // ch0 selects flags 0 and 2, ch1 selects none
    flag_in = 4'b0101;
    #1 check("R3 match not yet visible", match_out, 4'h0);
    step(); check("R1 exact subset matches", match_out, 4'b0001);
    flag_in = 4'b0111;
    step(); check("R1 unselected flag ignored", match_out, 4'b0001);
    flag_in = 4'b0100;
    step(); check("R1 partial subset no match", match_out, 4'b0000);
    flag_in = 4'b1111;
    step(); check("R2 empty selection never matches", match_out, 4'b0001);
    flag_in = 4'b0000;
    wr(0, 32'h0);
    step();
  endtask

  task automatic t_events();
    req_in = 4'h0; flag_in = 4'h0;
    wr(1, 32'hC001_E001);  // ch2 evt on, ch3 evt off, both block, select flag 0
    step(); check("R4 idle no pulse", irq_out, 4'h0);
    flag_in = 4'b0001;
    step();
    check("R4 R6 rise pulse", irq_out, 4'b0100);
    check("R4 match level", match_out, 4'b1100);
    step(); check("R4 pulse one cycle", irq_out, 4'b0000);
    flag_in = 4'b0000;
    step();
    check("R5 R6 fall pulse", irq_out, 4'b0100);
    check("R5 match cleared", match_out, 4'b0000);
    step(); check("R5 pulse one cycle", irq_out, 4'b0000);
    check("R6 gate stays low", gate_out, 4'b0000);
    wr(1, 32'h0);
    step();
  endtask

  task automatic t_gating();
    flag_in = 4'h0; req_in = 4'hF;
    wr(0, 32'h4001_0001);  // ch0 pass, ch1 on-match
    wr(1, 32'hC001_8001);  // ch2 on-miss, ch3 block
    step();
    check("R7 modes without match", gate_out, 4'b0101);
    check("R8 irq equals gate without events", irq_out, 4'b0101);
    flag_in = 4'b0001;
    step(); check("R7 modes with match", gate_out, 4'b0011);
    req_in = 4'h0;
    step(); check("R7 no request passes nothing", gate_out, 4'b0000);
    flag_in = 4'h0; req_in = 4'hF;
    wr(1, 32'hC001_A001);  // ch2 on-miss with event enable
    step(); check("R8 gate before change", gate_out, 4'b0101);
    flag_in = 4'b0001;
    step();
    check("R8 gate after change", gate_out, 4'b0011);
    check("R8 irq is gate or trigger", irq_out, 4'b0111);
    step(); check("R8 trigger gone", irq_out, 4'b0011);
    req_in = 4'h0; flag_in = 4'h0;
    wr(0, 32'h0); wr(1, 32'h0);
    step();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_regmap();
    t_select();
    t_events();
    t_gating();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule